// File: doc/BRIEF.md
# Time-Multiplexed Multi-Tap FIR Filter

This block is a finite impulse response filter built around a fixed bank of sixteen multiply-accumulate lanes. Each lane is reused over 1, 2, 4 or 8 clocks per result, so one bank can serve 16, 32, 64 or 128 taps. The source's sample rate falls as the tap count grows. Samples are 16-bit signed values. Coefficients are written as 16-bit signed values and are stored after being cut to 12 bits with rounding toward zero. Every product is summed in a 32-bit accumulator that wraps on overflow. A 32-bit cascade input from an upstream stage is added to each result at full precision.

Samples enter through a valid/ready handshake. The ready signal doubles as the sample-request strobe: it is raised only in the clocks where the schedule can take a new sample. If valid is low in such a clock, the schedule stalls and ready stays high until a sample arrives. The output has no back-pressure. Each result is shown for one clock by a valid pulse and then held. A split mode gives two independent filters, each with half the lanes, its own sample input and its own result. A decimating mode takes two samples per result and so doubles the taps available at a given input rate. The mode pins must be held steady and are changed only under reset.

Top module: `multicycle_fir`

## Requirements
- R1: A written coefficient c is stored as a 12-bit value q(c), which is c truncated toward zero after division by 16. A non-negative c loses its low 4 bits. A negative c has 15 added before its low 4 bits are dropped.
- R2: With tap_sel = k, the filter has 16·2^k taps (8·2^k per filter in split mode). When valid is held high, in_ready rises once every 2^k clocks and a result appears once every 2^k clocks.
- R3: In single mode without decimation, the result for sample n is the 32-bit sum over t < T of q(coef[t])·x[n−t] plus casc_in. Samples before the first one after reset count as zero.
- R4: casc_in is added unchanged, with no scaling, to every filter A result. It is not added to filter B.
- R5: With dual_en = 1, filter A uses din_a and coefficient addresses 0..8·2^k−1. Filter B uses din_b and addresses 64..64+8·2^k−1. Both filters share the handshake and out_valid.
- R6: With decim_en = 1 and tap_sel ≥ 1, a sample is requested every 2^(k−1) clocks and a result is produced for every second sample. Result j has sample 2j (counting from 0 after reset) as its newest term. With tap_sel = 0, decim_en has no effect.
- R7: A sample is taken only on a clock where in_ready and in_valid are both high. While in_ready is high and in_valid is low, the schedule holds and in_ready stays high. din values shown while in_ready is low have no effect on any result.
- R8: out_valid is high for exactly one clock per result. dout_a and dout_b keep their values between pulses.
- R9: Sums that exceed the 32-bit range wrap modulo 2^32 with no saturation.
- R10: While rst is high, in_ready and out_valid are low and the outputs are zero. Reset clears the sample history to zero.
- R11: In single mode, dout_b stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tap_sel | input | 2 | Clocks per result as a power of two (0..3) |
| dual_en | input | 1 | Split the bank into two filters |
| decim_en | input | 1 | Take two samples per result |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 7 | Coefficient address |
| coef_data | input | 16 | Signed coefficient to store |
| in_valid | input | 1 | Source has a sample on din_a/din_b |
| in_ready | output | 1 | Sample request strobe / ready |
| din_a | input | 16 | Signed sample for filter A |
| din_b | input | 16 | Signed sample for filter B |
| casc_in | input | 32 | Cascade value added to result A |
| out_valid | output | 1 | One-clock result pulse |
| dout_a | output | 32 | Result of filter A (or the single filter) |
| dout_b | output | 32 | Result of filter B |

## Verification
Two events can land in the same clock. In decimating mode, the second sample of a pair is shifted into the history while the accumulation is half done, so every later phase has to read one slot further back. In the 16-tap mode, a new sample is taken in the same clock that finishes a result. The bench sweeps every combination of tap count, split and decimation, inserts stalls in the middle of results, and compares each result with a convolution the bench computes itself. Any misaligned tap shows up as a wrong sum.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;
  localparam int FIR_MAXLOG = 3;
  localparam int FIR_MAXPH  = 1 << FIR_MAXLOG;
  localparam int FIR_TSW    = $clog2(FIR_MAXLOG + 1);

  typedef logic [FIR_MAXLOG-1:0] phase_t;

  typedef struct packed {
    phase_t phase;
    logic   active;
    logic   first;
    logic   last;
    logic   off;
    logic   take;
  } sched_t;
endpackage

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  parameter int CW    = 12,
  localparam int AW_C = $clog2(DEPTH),
  localparam int SH   = DW - CW
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW_C-1:0]      addr,
  input  logic [DW-1:0]        data,
  output logic signed [CW-1:0] q [DEPTH]
);
  logic signed [DW:0]   biased;
  logic signed [CW-1:0] qv;

  // toward-zero cut: negative values are biased up before the shift
  always_comb begin
    biased = {data[DW-1], data};
    if (data[DW-1]) biased = biased + (DW+1)'((1 << SH) - 1);
    qv = biased[SH+CW-1:SH];
  end

  always_ff @(posedge clk) begin
    if (we) q[addr] <= qv;
  end
endmodule

// File: rtl/fir_sample_hist.sv
module fir_sample_hist #(
  parameter int DEPTH = 129,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic [DW-1:0]        din,
  output logic signed [DW-1:0] view [DEPTH]
);
  logic signed [DW-1:0] hist [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    if (i == 0) begin : g_head
      assign view[i] = take ? din : hist[i];
    end else begin : g_body
      assign view[i] = take ? hist[i-1] : hist[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
    end else if (take) begin
      for (int k = 0; k < DEPTH; k++) hist[k] <= view[k];
    end
  end
endmodule

// File: rtl/fir_mac_sched.sv
module fir_mac_sched
  import fir_mc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FIR_TSW-1:0] tap_sel,
  input  logic               decim_en,
  input  logic               in_valid,
  output logic               in_ready,
  output sched_t             s
);
  phase_t              cnt;
  logic                run;
  logic [FIR_MAXLOG:0] mcount;
  phase_t              mlast, half;
  logic                dec_eff, acc_pt;

  always_comb begin
    mcount     = (FIR_MAXLOG+1)'(1) << tap_sel;
    mlast      = FIR_MAXLOG'(mcount - 1'b1);
    half       = FIR_MAXLOG'(mcount >> 1);
    dec_eff    = decim_en && (tap_sel != '0);
    acc_pt     = (cnt == '0) || (dec_eff && cnt == half);
    in_ready   = run && acc_pt;
    s.take     = in_ready && in_valid;
    s.active   = run && !(acc_pt && !in_valid);
    s.first    = s.active && (cnt == '0);
    s.last     = s.active && (cnt == mlast);
    s.off      = dec_eff && (cnt >= half);
    s.phase    = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      run <= 1'b1;
      if (s.active) cnt <= s.last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fir_mac_lane.sv
module fir_mac_lane #(
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic signed [DW-1:0] dat,
  input  logic signed [CW-1:0] cq,
  output logic signed [AW-1:0] prod
);
  logic signed [DW+CW-1:0] p;
  always_comb begin
    p    = dat * cq;
    prod = {{(AW-DW-CW){p[DW+CW-1]}}, p};
  end
endmodule

// File: rtl/multicycle_fir.sv
module multicycle_fir
  import fir_mc_pkg::*;
#(
  parameter int NMAC = 16,
  parameter int DW   = 16,
  parameter int CW   = 12,
  parameter int AW   = 32,
  localparam int DEPTH = NMAC * FIR_MAXPH,
  localparam int HALFM = NMAC / 2,
  localparam int CAW   = $clog2(DEPTH),
  localparam int HDA   = DEPTH + 1,
  localparam int HDB   = DEPTH / 2 + 1,
  localparam int IAW   = $clog2(HDA),
  localparam int IBW   = $clog2(HDB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIR_TSW-1:0] tap_sel,
  input  logic               dual_en,
  input  logic               decim_en,
  input  logic               coef_we,
  input  logic [CAW-1:0]     coef_addr,
  input  logic [DW-1:0]      coef_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      din_a,
  input  logic [DW-1:0]      din_b,
  input  logic [AW-1:0]      casc_in,
  output logic               out_valid,
  output logic [AW-1:0]      dout_a,
  output logic [AW-1:0]      dout_b
);
  sched_t               s;
  logic signed [CW-1:0] cq   [DEPTH];
  logic signed [DW-1:0] va   [HDA];
  logic signed [DW-1:0] vb   [HDB];
  logic signed [AW-1:0] prod [NMAC];
  logic signed [AW-1:0] sum_lo, sum_hi, sa, sb, na, nb, acc_a, acc_b;

  fir_mac_sched u_sched (
    .clk(clk), .rst(rst), .tap_sel(tap_sel), .decim_en(decim_en),
    .in_valid(in_valid), .in_ready(in_ready), .s(s)
  );

  fir_coef_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_coef (
    .clk(clk), .we(coef_we), .addr(coef_addr), .data(coef_data), .q(cq)
  );

  fir_sample_hist #(.DEPTH(HDA), .DW(DW)) u_hist_a (
    .clk(clk), .rst(rst), .take(s.take), .din(din_a), .view(va)
  );

  fir_sample_hist #(.DEPTH(HDB), .DW(DW)) u_hist_b (
    .clk(clk), .rst(rst), .take(s.take), .din(din_b), .view(vb)
  );

  for (genvar j = 0; j < NMAC; j++) begin : g_lane
    localparam int JJ = j % HALFM;
    localparam int FB = j / HALFM;
    logic [IAW-1:0]       ia;
    logic [IBW-1:0]       ib;
    logic [CAW-1:0]       ci;
    logic signed [DW-1:0] d;

    always_comb begin
      if (dual_en) begin
        ia = IAW'(int'(s.phase) * HALFM + JJ + int'(s.off));
        ib = IBW'(int'(s.phase) * HALFM + JJ + int'(s.off));
        ci = CAW'(FB * (DEPTH / 2) + int'(s.phase) * HALFM + JJ);
        d  = (FB == 1) ? vb[ib] : va[ia];
      end else begin
        ia = IAW'(int'(s.phase) * NMAC + j + int'(s.off));
        ib = '0;
        ci = CAW'(int'(s.phase) * NMAC + j);
        d  = va[ia];
      end
    end

    fir_mac_lane #(.DW(DW), .CW(CW), .AW(AW)) u_lane (
      .dat(d), .cq(cq[ci]), .prod(prod[j])
    );
  end

  always_comb begin
    sum_lo = '0;
    sum_hi = '0;
    for (int j = 0; j < NMAC; j++) begin
      if (j < HALFM) sum_lo = sum_lo + prod[j];
      else           sum_hi = sum_hi + prod[j];
    end
    sa = dual_en ? sum_lo : sum_lo + sum_hi;
    sb = sum_hi;
    na = (s.first ? '0 : acc_a) + sa;
    nb = (s.first ? '0 : acc_b) + sb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a     <= '0;
      acc_b     <= '0;
      dout_a    <= '0;
      dout_b    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= s.last;
      if (s.active) begin
        acc_a <= na;
        acc_b <= nb;
      end
      if (s.last) begin
        dout_a <= na + casc_in;
        dout_b <= dual_en ? nb : '0;
      end
    end
  end
endmodule

// File: rtl/fir_mc_checker.sv
module fir_mc_checker
  import fir_mc_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [FIR_TSW-1:0] tap_sel,
  input logic               dual_en,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic [AW-1:0]      dout_a,
  input logic [AW-1:0]      dout_b
);
  assert_hold_request_R7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ((tap_sel != '0) && out_valid) |=> !out_valid);

  assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(dout_a) && $stable(dout_b)));

  assert_slow_request_R2: assert property (@(posedge clk) disable iff (rst)
    ((tap_sel == FIR_TSW'(FIR_MAXLOG)) && in_ready && in_valid) |=> !in_ready);

  assert_b_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !dual_en |-> (dout_b == '0));
endmodule

bind multicycle_fir fir_mc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tap_sel(tap_sel), .dual_en(dual_en),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .dout_a(dout_a), .dout_b(dout_b)
);

// File: tb/multicycle_fir_test.sv
module multicycle_fir_test;
  localparam int NS = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  tap_sel = '0;
  logic        dual_en = 1'b0, decim_en = 1'b0, coef_we = 1'b0, in_valid = 1'b0;
  logic [6:0]  coef_addr = '0;
  logic [15:0] coef_data = '0, din_a = '0, din_b = '0;
  logic [31:0] casc_in = '0;
  logic        in_ready, out_valid;
  logic [31:0] dout_a, dout_b;

  int checks = 0, errors = 0, cyc = 0;
  int cm [128];
  int xa [NS];
  int xb [NS];

  multicycle_fir uut (
    .clk(clk), .rst(rst), .tap_sel(tap_sel), .dual_en(dual_en), .decim_en(decim_en),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_ready(in_ready), .din_a(din_a), .din_b(din_b),
    .casc_in(casc_in), .out_valid(out_valid), .dout_a(dout_a), .dout_b(dout_b)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R7 watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int q16(input int c);
    return (c >= 0) ? c / 16 : -((-c) / 16);
  endfunction

  function automatic int cval(input int i, input int seed, input int csel, input int v);
    if (csel == 1) return (i == 0) ? v : 0;
    if (csel == 2) return 32767;
    case (i % 13)
      3: return -1;
      5: return -16;
      7: return -17;
      9: return -32768;
      default: return ((i * 7919 + seed * 1237 + 11) % 65536) - 32768;
    endcase
  endfunction

  function automatic int xv(input int n, input int seed, input int csel);
    if (csel == 1) return (n == 0) ? 1 : 0;
    if (csel == 2) return 32767;
    if (n % 11 == 4) return -32768;
    return ((n * 4091 + seed * 613 + 7) % 65536) - 32768;
  endfunction

  function automatic logic [31:0] model(input int n, input bit fb, input int taps,
                                        input int base, input bit addc);
    longint acc = addc ? longint'($signed(casc_in)) : 0;
    for (int t = 0; t < taps; t++) begin
      if (n - t >= 0)
        acc += longint'(q16(cm[base + t])) * longint'(fb ? xb[n - t] : xa[n - t]);
    end
    return acc[31:0];
  endfunction

  task automatic run_cfg(input int ts, input bit du, input bit dc, input int seed,
                         input int csel, input int cv, input string tag);
    int m = 1 << ts;
    bit de = dc && (ts != 0);
    int pin = de ? m / 2 : m;
    int nexp = de ? NS / 2 : NS;
    int taps = du ? 8 * m : 16 * m;
    int ns = 0, k = 0, guard = 0, last_hs = 0, last_out = 0, n;
    bit stall_chk = 0;
    logic [31:0] hold_a = '0, ea, eb;
    string rt;

    @(negedge clk);
    rst = 1'b1; tap_sel = 2'(ts); dual_en = du; decim_en = dc; in_valid = 1'b0;
    casc_in = (csel == 1) ? 32'd0 : (csel == 2) ? 32'h7fff_f000 : 32'(seed) * 32'h0123_4567;
    for (int i = 0; i < 128; i++) begin
      cm[i] = cval(i, seed, csel, cv);
      coef_we = 1'b1; coef_addr = 7'(i); coef_data = 16'(cm[i]);
      @(negedge clk);
    end
    coef_we = 1'b0;
    // R10: state under reset
    chk(in_ready == 1'b0, "R10 in_ready during reset", in_ready, 0);
    chk(out_valid == 1'b0, "R10 out_valid during reset", out_valid, 0);
    chk(dout_a == 32'd0, "R10 dout_a during reset", dout_a, 0);
    @(negedge clk);
    rst = 1'b0;
    rt = de ? "R6" : "R2";

    while (k < nexp && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (stall_chk) chk(in_ready == 1'b1, "R7 request held while stalled", in_ready, 1);
      stall_chk = 0;
      if (out_valid) begin
        n = de ? 2 * k : k;
        ea = model(n, 1'b0, taps, 0, 1'b1);
        chk(dout_a == ea, $sformatf("%s R4 filter A result %0d", tag, k),
            $signed(dout_a), $signed(ea));
        if (du) begin
          eb = model(n, 1'b1, taps, 64, 1'b0);
          chk(dout_b == eb, $sformatf("R5 filter B result %0d", k), $signed(dout_b), $signed(eb));
        end else begin
          chk(dout_b == 32'd0, "R11 dout_b in single mode", dout_b, 0);
        end
        if (k >= 1 && k <= 4)
          chk(cyc - last_out == m, $sformatf("%s result spacing", rt), cyc - last_out, m);
        last_out = cyc;
        hold_a = dout_a;
        k++;
      end else if (k > 0) begin
        chk(dout_a == hold_a, "R8 result held between pulses", dout_a, hold_a);
      end

      in_valid = (ns < NS) && !(ns >= 12 && (guard % 5 == 2));
      if (in_ready) begin
        din_a = 16'(xv(ns, seed, csel));
        din_b = 16'(xv(ns + 50, seed + 3, csel));
      end else begin
        din_a = 16'h5a5a ^ 16'(cyc);
        din_b = 16'ha5a5 ^ 16'(cyc);
      end
      if (in_ready && in_valid) begin
        xa[ns] = int'($signed(din_a));
        xb[ns] = int'($signed(din_b));
        if (ns >= 1 && ns <= 8)
          chk(cyc - last_hs == pin, $sformatf("%s request spacing", rt), cyc - last_hs, pin);
        last_hs = cyc;
        ns++;
      end else if (in_ready && !in_valid && ns < NS) begin
        stall_chk = 1;
      end
    end
    chk(k == nexp, $sformatf("%s result count", rt), k, nexp);
  endtask

  initial begin
    int vals [10] = '{-1, -15, -16, -17, 15, 16, 17, -32768, 32767, 1000};
    for (int ts = 0; ts < 4; ts++)
      for (int du = 0; du < 2; du++)
        for (int dc = 0; dc < 2; dc++)
          run_cfg(ts, du[0], dc[0], ts * 4 + du * 2 + dc + 1, 0, 0,
                  du ? "R5" : ((dc != 0 && ts != 0) ? "R6" : "R3"));
    foreach (vals[i]) run_cfg(0, 1'b0, 1'b0, 0, 1, vals[i], "R1");
    run_cfg(3, 1'b0, 1'b0, 0, 2, 0, "R9");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule